// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Access Checks

This block is a small, fully associative cache of page translations. Each entry holds a virtual page number, an address-space tag, a physical frame number and a set of attribute bits. A lookup presents a page number, the current address-space tag, the kind of access and the privilege level. Every valid entry is compared in parallel in the same cycle. The block reports a hit with the frame number, or a miss. On a hit it also reports whether the access breaks the entry's attributes.

After a miss, a page walker outside this block fetches the translation and writes it in through the fill port. Because entries carry address-space tags, a context switch does not need a flush. Entries marked global, such as kernel mappings, match under any tag. Entries marked locked are never chosen for replacement and are never removed by a flush. Two flush commands exist: one clears everything that is not locked, and the other clears the non-global entries of a single address space.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and `lk_pfn` reads 0. `lk_pfn` is also 0 whenever `lk_hit` is low.
- R2: A lookup hits when some valid entry has an equal page number and either an equal address-space tag or the global attribute. `lk_pfn` then returns that entry's frame number in the same cycle. When several entries match, the lowest index wins.
- R3: An entry whose `fill_attr[5]` (global) was set matches a lookup with any `lk_asid`.
- R4: A fill is compared against the valid entries. If one has an equal page number and either an equal tag or the global attribute, the lowest such entry is overwritten in place, and no second entry is created.
- R5: A fill that matches nothing goes to the first entry, starting at the replacement pointer and wrapping, that is not both valid and locked (`fill_attr[6]`). The pointer then moves to that entry plus one, modulo the entry count. The pointer starts at 0 and does not move on an overwrite. If every entry is locked, the fill is dropped.
- R6: `flush_all` invalidates every entry except valid locked entries, which remain usable.
- R7: `flush_asid_en` invalidates only those entries whose tag equals `flush_asid` and that are neither global nor locked. Entries of other tags, global entries and locked entries still hit afterwards.
- R8: A hit faults (`lk_fault`=1) when any of these holds:
  - the entry is not present (`fill_attr[0]`=0);
  - the access is user mode (`lk_kernel`=0) and the entry is not user-accessible (`fill_attr[1]`=0);
  - the access is a store (`lk_acc`=1) and the entry is not writable (`fill_attr[2]`=0);
  - the access is a fetch (`lk_acc`=2) and the entry is no-execute (`fill_attr[3]`=1).
  
  Loads use `lk_acc`=0, and the code 3 is treated as a load.
- R9: A fetch in kernel mode (`lk_kernel`=1, `lk_acc`=2) from an entry with `fill_attr[4]`=1 (no kernel execute) faults. The same entry does not fault a user-mode fetch.
- R10: When a fill and a flush arrive in the same cycle, the flush takes effect first and the fill is written afterwards, so the filled entry is valid on the next cycle.
- R11: `lk_hit` and `lk_miss` are never high together, and both are low when `lk_valid` is low. `lk_fault` is high only together with `lk_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no matching entry |
| lk_pfn | output | PFN_W | Frame number of the hit, else 0 |
| lk_fault | output | 1 | Hit breaks the entry's attributes |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number to write |
| fill_asid | input | ASID_W | Tag to write |
| fill_pfn | input | PFN_W | Frame number to write |
| fill_attr | input | 7 | [0] present, [1] user, [2] writable, [3] no-exec, [4] no kernel exec, [5] global, [6] locked |
| flush_all | input | 1 | Invalidate all entries that are not locked |
| flush_asid_en | input | 1 | Invalidate the entries of one tag |
| flush_asid | input | ASID_W | Tag that `flush_asid_en` clears |

## Verification
The bench goes after the case where a global entry and a tagged entry share one page number. A design that ignored the global attribute on fills would duplicate the entry, and one that checked only tags would miss kernel pages. Locked entries are checked across both flush kinds and across a full wrap of the replacement pointer. A pointer that did not skip them would overwrite a pinned mapping, which then misses. Same-cycle fill and flush is checked because a design that flushes after filling loses the new entry. Kernel fetches from no-kernel-execute pages are checked because a design that treated that bit like the general no-exec bit would also fault user fetches.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
   localparam int ATTR_W       = 7;
   localparam int ATTR_PRESENT = 0;
   localparam int ATTR_USER    = 1;
   localparam int ATTR_WRITE   = 2;
   localparam int ATTR_NOEXEC  = 3;
   localparam int ATTR_NOKEXEC = 4;
   localparam int ATTR_GLOBAL  = 5;
   localparam int ATTR_LOCKED  = 6;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic              ent_valid,
   input  logic              ent_global,
   input  logic [VPN_W-1:0]  ent_vpn,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   output logic              match
);
   logic tag_ok;
   assign tag_ok = ent_global | (ent_asid == key_asid);
   assign match  = ent_valid & (ent_vpn == key_vpn) & tag_ok;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [IDX_W-1:0]   ptr,
   input  logic [ENTRIES-1:0] locked,
   output logic [IDX_W-1:0]   victim,
   output logic               found
);
   logic [IDX_W-1:0] cand;

   // Walk backwards so the smallest offset from the pointer is kept last.
   always_comb begin
      victim = ptr;
      found  = 1'b0;
      cand   = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         cand = ptr + IDX_W'(k);
         if (!locked[cand]) begin
            victim = cand;
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
   import asid_tlb_pkg::*;
(
   input  logic [ATTR_W-1:0] attr,
   input  logic [1:0]        acc,
   input  logic              kernel,
   output logic              fault
);
   logic is_store, is_fetch;
   logic no_present, no_user, no_write, no_exec, no_kexec;

   assign is_store   = (acc == ACC_STORE);
   assign is_fetch   = (acc == ACC_FETCH);
   assign no_present = ~attr[ATTR_PRESENT];
   assign no_user    = ~kernel & ~attr[ATTR_USER];
   assign no_write   = is_store & ~attr[ATTR_WRITE];
   assign no_exec    = is_fetch & attr[ATTR_NOEXEC];
   assign no_kexec   = is_fetch & kernel & attr[ATTR_NOKEXEC];
   assign fault      = no_present | no_user | no_write | no_exec | no_kexec;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import asid_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_acc,
   input  logic              lk_kernel,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic              lk_fault,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid
);
   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("asid_tlb: ENTRIES must be a power of two of at least 2");
      end
      if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
         $error("asid_tlb: field widths must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_vec, valid_nxt;
   logic [ENTRIES-1:0] wired_vec, global_vec, kill_vec;
   logic [ENTRIES-1:0] lk_hitv, fl_hitv;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];
   logic [ATTR_W-1:0]  attr_q [ENTRIES];
   logic [IDX_W-1:0]   rr_ptr, vic_idx, lk_sel, fl_sel, wr_idx;
   logic               vic_found, fl_any, fill_do, perm_fault;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         assign wired_vec[i]  = valid_vec[i] & attr_q[i][ATTR_LOCKED];
         assign global_vec[i] = attr_q[i][ATTR_GLOBAL];
         assign kill_vec[i]   = ~wired_vec[i] &
                                (flush_all |
                                 (flush_asid_en & ~global_vec[i] & (asid_q[i] == flush_asid)));

         tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
            .ent_valid (valid_vec[i]),
            .ent_global(global_vec[i]),
            .ent_vpn   (vpn_q[i]),
            .ent_asid  (asid_q[i]),
            .key_vpn   (lk_vpn),
            .key_asid  (lk_asid),
            .match     (lk_hitv[i])
         );

         tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cmp (
            .ent_valid (valid_vec[i]),
            .ent_global(global_vec[i]),
            .ent_vpn   (vpn_q[i]),
            .ent_asid  (asid_q[i]),
            .key_vpn   (fill_vpn),
            .key_asid  (fill_asid),
            .match     (fl_hitv[i])
         );
      end
   endgenerate

   // Lowest matching index wins for both lookup and fill overwrite.
   always_comb begin
      lk_sel = '0;
      fl_sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_hitv[i]) lk_sel = IDX_W'(i);
         if (fl_hitv[i]) fl_sel = IDX_W'(i);
      end
   end

   tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .ptr   (rr_ptr),
      .locked(wired_vec),
      .victim(vic_idx),
      .found (vic_found)
   );

   tlb_perm u_perm (
      .attr  (attr_q[lk_sel]),
      .acc   (lk_acc),
      .kernel(lk_kernel),
      .fault (perm_fault)
   );

   assign fl_any  = |fl_hitv;
   assign fill_do = fill_en & (fl_any | vic_found);
   assign wr_idx  = fl_any ? fl_sel : vic_idx;

   // Flush applies first, then a same-cycle fill sets its entry.
   always_comb begin
      valid_nxt = valid_vec & ~kill_vec;
      if (fill_do) valid_nxt[wr_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_vec <= '0;
         rr_ptr    <= '0;
      end else begin
         valid_vec <= valid_nxt;
         if (fill_en && !fl_any && vic_found) rr_ptr <= vic_idx + IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (fill_do) begin
         vpn_q[wr_idx]  <= fill_vpn;
         asid_q[wr_idx] <= fill_asid;
         pfn_q[wr_idx]  <= fill_pfn;
         attr_q[wr_idx] <= fill_attr;
      end
   end

   assign lk_hit   = lk_valid & (|lk_hitv);
   assign lk_miss  = lk_valid & ~(|lk_hitv);
   assign lk_pfn   = lk_hit ? pfn_q[lk_sel] : '0;
   assign lk_fault = lk_hit & perm_fault;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic               fill_en,
   input logic               flush_all,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] wired_vec,
   input logic [IDX_W-1:0]   rr_ptr
);
   // R11
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss));

   // R8
   fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   // R1
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && valid_vec == '0) |-> lk_miss);

   // R6
   flush_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !fill_en) |=> ((valid_vec & ~$past(wired_vec)) == '0));

   // R6
   locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |=> (($past(wired_vec) & ~valid_vec) == '0));

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |=> $stable(rr_ptr));
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_hit   (lk_hit),
   .lk_miss  (lk_miss),
   .lk_fault (lk_fault),
   .fill_en  (fill_en),
   .flush_all(flush_all),
   .valid_vec(valid_vec),
   .wired_vec(wired_vec),
   .rr_ptr   (rr_ptr)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
   localparam int N  = 16;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic [1:0]    lk_acc = '0;
   logic          lk_kernel = 1'b0;
   logic          lk_hit, lk_miss, lk_fault;
   logic [PW-1:0] lk_pfn;
   logic          fill_en = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [AW-1:0] fill_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic [6:0]    fill_attr = '0;
   logic          flush_all = 1'b0;
   logic          flush_asid_en = 1'b0;
   logic [AW-1:0] flush_asid = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model
   bit            m_v    [N];
   logic [VW-1:0] m_vpn  [N];
   logic [AW-1:0] m_asid [N];
   logic [PW-1:0] m_pfn  [N];
   logic [6:0]    m_attr [N];
   int            m_ptr;

   always #2 clk = ~clk;

   asid_tlb i_asid_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
      .lk_kernel(lk_kernel), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
      .lk_fault(lk_fault), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_attr(fill_attr), .flush_all(flush_all),
      .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
   );

   function automatic int m_find(logic [VW-1:0] v, logic [AW-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_vpn[i] == v && (m_attr[i][5] || m_asid[i] == a)) return i;
      return -1;
   endfunction

   function automatic bit exp_fault(logic [6:0] at, logic [1:0] acc, bit kern);
      bit f;
      f = !at[0];
      if (!kern && !at[1]) f = 1;
      if (acc == 2'd1 && !at[2]) f = 1;
      if (acc == 2'd2 && at[3]) f = 1;
      if (acc == 2'd2 && kern && at[4]) f = 1;
      return f;
   endfunction

   task automatic model_step(bit fe, logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p,
                             logic [6:0] at, bit fa, bit fae, logic [AW-1:0] fas);
      int fidx, vic, idx;
      fidx = m_find(v, a);
      vic = -1;
      for (int k = 0; k < N; k++) begin
         idx = (m_ptr + k) % N;
         if (vic < 0 && !(m_v[idx] && m_attr[idx][6])) vic = idx;
      end
      for (int i = 0; i < N; i++)
         if (!(m_v[i] && m_attr[i][6]) && (fa || (fae && !m_attr[i][5] && m_asid[i] == fas)))
            m_v[i] = 0;
      if (fe) begin
         idx = (fidx >= 0) ? fidx : vic;
         if (idx >= 0) begin
            m_v[idx] = 1; m_vpn[idx] = v; m_asid[idx] = a; m_pfn[idx] = p; m_attr[idx] = at;
            if (fidx < 0) m_ptr = (vic + 1) % N;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
   endtask

   task automatic do_op(bit fe, logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p,
                        logic [6:0] at, bit fa, bit fae, logic [AW-1:0] fas);
      @(negedge clk);
      fill_en = fe; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_attr = at;
      flush_all = fa; flush_asid_en = fae; flush_asid = fas;
      model_step(fe, v, a, p, at, fa, fae, fas);
      @(posedge clk);
      #1 fill_en = 0; flush_all = 0; flush_asid_en = 0;
   endtask

   task automatic fill(logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p, logic [6:0] at);
      do_op(1, v, a, p, at, 0, 0, '0);
   endtask

   task automatic look(logic [VW-1:0] v, logic [AW-1:0] a, logic [1:0] acc, bit kern,
                       string req);
      int idx;
      bit eh, ef;
      logic [PW-1:0] ep;
      @(negedge clk);
      lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc; lk_kernel = kern;
      #1;
      idx = m_find(v, a);
      eh = (idx >= 0);
      ep = eh ? m_pfn[idx] : '0;
      ef = eh ? exp_fault(m_attr[idx], acc, kern) : 1'b0;
      n_checks++;
      if (lk_hit !== eh || lk_miss !== !eh || lk_pfn !== ep || lk_fault !== ef) begin
         n_fail++;
         $display("FAIL %s vpn=%0h asid=%0h: hit/miss/pfn/fault actual %b/%b/%0h/%b expected %b/%b/%0h/%b",
                  req, v, a, lk_hit, lk_miss, lk_pfn, lk_fault, eh, !eh, ep, ef);
      end
      lk_valid = 0;
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250917));
      do_reset();

      // R1: empty after reset
      look(20'h10, 8'h1, 2'd0, 0, "R1");
      look(20'h0, 8'h0, 2'd2, 1, "R1");

      // R11: idle lookup gives neither hit nor miss
      @(negedge clk); #1;
      n_checks++;
      if (lk_hit !== 0 || lk_miss !== 0) begin
         n_fail++;
         $display("FAIL R11 idle: actual %b/%b expected 0/0", lk_hit, lk_miss);
      end

      // R2: tag-sensitive match
      fill(20'h10, 8'h1, 20'hAAAAA, 7'b0000111);
      look(20'h10, 8'h1, 2'd1, 0, "R2");
      look(20'h10, 8'h2, 2'd0, 0, "R2");
      // R3: global entry matches any tag
      fill(20'h20, 8'h5, 20'h12345, 7'b0100101);
      look(20'h20, 8'h9, 2'd0, 1, "R3");
      look(20'h20, 8'hFE, 2'd0, 0, "R3 user on kernel page R8");
      // R4: overwrite same page/tag
      fill(20'h10, 8'h1, 20'h55555, 7'b0000011);
      look(20'h10, 8'h1, 2'd1, 0, "R4 store to read-only R8");
      // R2: tagged entry and global entry on one page, lowest index wins
      fill(20'h30, 8'h3, 20'h00333, 7'b0000011);
      fill(20'h30, 8'h4, 20'h00444, 7'b0100011);
      look(20'h30, 8'h3, 2'd0, 0, "R2 lowest index");
      // R9: kernel fetch from no-kernel-exec page
      fill(20'h40, 8'h1, 20'h00040, 7'b0010011);
      look(20'h40, 8'h1, 2'd2, 1, "R9");
      look(20'h40, 8'h1, 2'd2, 0, "R9 user fetch");
      // R8: no-exec and non-present
      fill(20'h41, 8'h1, 20'h00041, 7'b0001011);
      look(20'h41, 8'h1, 2'd2, 0, "R8 noexec");
      fill(20'h42, 8'h1, 20'h00042, 7'b0000110);
      look(20'h42, 8'h1, 2'd0, 1, "R8 not present");
      look(20'h42, 8'h1, 2'd3, 1, "R8 code 3");

      // R7: flush one tag
      do_op(0, '0, '0, '0, '0, 0, 1, 8'h1);
      look(20'h41, 8'h1, 2'd0, 0, "R7 cleared");
      look(20'h20, 8'h1, 2'd0, 1, "R7 global kept");
      look(20'h30, 8'h3, 2'd0, 0, "R7 other tag kept");

      // R5/R6: locked entry survives flush and is skipped on wrap
      do_reset();
      fill(20'h100, 8'h7, 20'h0F00D, 7'b1000111);
      do_op(0, '0, '0, '0, '0, 1, 0, '0);
      look(20'h100, 8'h7, 2'd0, 0, "R6 locked kept");
      for (int i = 0; i < N; i++) fill(20'h200 + 20'(i), 8'h2, 20'h300 + 20'(i), 7'b0000011);
      look(20'h100, 8'h7, 2'd0, 0, "R5 locked not replaced");
      look(20'h200, 8'h2, 2'd0, 0, "R5 wrap evicts oldest");
      look(20'h20F, 8'h2, 2'd0, 0, "R5 newest present");
      look(20'h201, 8'h2, 2'd0, 0, "R5 next kept");

      // R10: fill with flush_all in the same cycle
      do_op(1, 20'h500, 8'h9, 20'h00500, 7'b0000011, 1, 0, '0);
      look(20'h500, 8'h9, 2'd0, 0, "R10");
      look(20'h201, 8'h2, 2'd0, 0, "R10 R6 flushed");

      // random mix, with the model computing expected values
      do_reset();
      for (int it = 0; it < 3000; it++) begin
         int r;
         logic [6:0] at;
         r = int'($urandom % 16);
         at = 7'($urandom);
         at[0] = ($urandom % 8) != 0;
         at[6] = ($urandom % 10) == 0;
         if (r < 6)
            fill(20'($urandom % 24), 8'($urandom % 4), 20'($urandom), at);
         else if (r < 14)
            look(20'($urandom % 24), 8'($urandom % 4), 2'($urandom), 1'($urandom),
                 "R2 R8 random");
         else if (r == 14)
            do_op(($urandom % 2) == 1, 20'($urandom % 24), 8'($urandom % 4), 20'($urandom),
                  at, 0, 1, 8'($urandom % 4));
         else
            do_op(($urandom % 2) == 1, 20'($urandom % 24), 8'($urandom % 4), 20'($urandom),
                  at, 1, 0, '0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule